// File: doc/BRIEF.md
# DTMF Steering Guard-Time Controller

This block is the validation and output stage that follows a DTMF tone-pair detector. It takes the detector's early steering flag, which is high while a valid pair of frequencies is heard, and the 4-bit key code of that pair. Clock-tick counters replace an external RC steering network. A key is accepted only when the pair has been present without a break for a programmable number of ticks. The accepted code is then captured in an output latch. A delayed steering flag rises a few ticks after the capture, so the data has settled before a consumer samples it. The flag falls only after the tone has been absent for a programmable number of ticks.

Because the accept and release times differ, the block ignores bursts that are too short and also short gaps inside a tone. The latched code persists after the tone ends, until the next key is accepted. An inhibit input keeps the four letter keys from being registered. A power-down input sends the steering logic back to idle but keeps the latched code. The output enable decides whether the code is presented. A pad-level tri-state buffer is driven from the separate output-enable port.

Top module: `dtmf_guard_ctrl`

## Requirements
- R1: A key code is captured into the output latch on the clock edge at which earlySteer has been sampled high on PRESENT_TICKS consecutive edges, starting from idle. A burst of PRESENT_TICKS-1 edges or fewer leaves the latch and delayedSteer unchanged.
- R2: delayedSteer rises SETTLE_TICKS edges after the capture edge. The captured code is already on codeOut before the rise and does not change at the rise.
- R3: Once registered, delayedSteer falls on the edge at which earlySteer has been sampled low on ABSENT_TICKS consecutive edges, and the controller returns to idle.
- R4: A low gap of fewer than ABSENT_TICKS edges does not release the registration. delayedSteer stays high, and a different code arriving after the gap is not captured.
- R5: While outEnable is 1, codeOut shows the latched code and codeOutEn is 1. While outEnable is 0, codeOut reads 0 and codeOutEn is 0, and the latch is kept. The latch keeps its value after the tone ends.
- R6: Key encoding: keys 1 to 9 are codes 1 to 9, key 0 is 10, star is 11, hash is 12, A is 13, B is 14, C is 15 and D is 0. While inhibit is 1, codes 13, 14, 15 and 0 are never registered, and the latch keeps its previous code. All other codes are still registered.
- R7: While powerDown is 1, the controller is held idle, delayedSteer is 0 from the next edge, no code is captured, and the latch keeps its contents.
- R8: After reset, delayedSteer is 0 and the latched code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock for all guard timers |
| rstN | input | 1 | Asynchronous active-low reset |
| earlySteer | input | 1 | Detector flag, high while a valid tone pair is heard |
| keyCode | input | 4 | Decoded key code of the current tone pair |
| inhibit | input | 1 | Blocks registration of the four letter keys |
| powerDown | input | 1 | Holds the steering logic idle; the latch is kept |
| outEnable | input | 1 | Presents the latched code when high |
| codeOut | output | 4 | Latched key code, 0 while not enabled |
| codeOutEn | output | 1 | Drive enable for an external tri-state pad |
| delayedSteer | output | 1 | High from settle time after capture until absence release |

## Verification
On every cycle, the assertions check that codeOut never moves unless earlySteer was high at the prior edge and power was up. They also check that the code is steady when delayedSteer rises, that a fall of the flag always follows a low earlySteer or a power-down, that the flag is never high outside the registered state, and the zero parking of a disabled bus. The exact tick counts for accept, settle and release, the rejection of short bursts, the tolerance of short dropouts, the inhibit of letter keys and the persistence of the latch across power-down need driven sequences. The bench's scenarios show these, and its scoreboard matches every rise of delayedSteer against the code expected for that tone.

// File: rtl/dtmf_guard_pkg.sv
`timescale 1ns/1ps
package dtmf_guard_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PRESENT = 2'd1,
    ST_HELD    = 2'd2
  } steerState_t;

  typedef struct packed {
    logic loadCode;
    logic setFlag;
    logic clrFlag;
  } steerStrobes_t;

  // Letter keys A, B, C, D are encoded 13, 14, 15, 0 (R6)
  function automatic logic isLetterKey(input logic [3:0] key);
    return (key >= 4'd13) || (key == 4'd0);
  endfunction

endpackage

// File: rtl/dtmf_guard_fsm.sv
`timescale 1ns/1ps
module dtmf_guard_fsm
  import dtmf_guard_pkg::*;
#(
  parameter int PRESENT_TICKS = 16,
  parameter int ABSENT_TICKS  = 12,
  parameter int SETTLE_TICKS  = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          earlySteer,
  input  logic [3:0]    keyCode,
  input  logic          inhibit,
  input  logic          powerDown,
  output steerStrobes_t strobes,
  output logic          steerHeld
);

  localparam int MAX_TICKS = (PRESENT_TICKS > ABSENT_TICKS)
                           ? ((PRESENT_TICKS > SETTLE_TICKS) ? PRESENT_TICKS : SETTLE_TICKS)
                           : ((ABSENT_TICKS > SETTLE_TICKS) ? ABSENT_TICKS : SETTLE_TICKS);
  localparam int CNT_W = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] PRESENT_LAST = CNT_W'(PRESENT_TICKS - 1);
  localparam logic [CNT_W-1:0] ABSENT_LAST  = CNT_W'(ABSENT_TICKS - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST  = CNT_W'(SETTLE_TICKS - 1);
  localparam logic [CNT_W-1:0] SETTLE_DONE  = CNT_W'(SETTLE_TICKS);

  steerState_t      state, stateNxt;
  logic [CNT_W-1:0] guardCnt, guardNxt;
  logic [CNT_W-1:0] settleCnt, settleNxt;
  logic             toneOk;

  assign toneOk = earlySteer && !(inhibit && isLetterKey(keyCode));

  always_comb begin
    strobes   = '0;
    stateNxt  = state;
    guardNxt  = guardCnt;
    settleNxt = settleCnt;
    if (powerDown) begin
      stateNxt        = ST_IDLE;
      guardNxt        = '0;
      settleNxt       = '0;
      strobes.clrFlag = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (toneOk) begin
            stateNxt = ST_PRESENT;
            guardNxt = CNT_W'(1);
          end
        end
        ST_PRESENT: begin
          if (!toneOk) begin
            stateNxt = ST_IDLE;
            guardNxt = '0;
          end else if (guardCnt == PRESENT_LAST) begin
            strobes.loadCode = 1'b1;
            stateNxt  = ST_HELD;
            guardNxt  = '0;
            settleNxt = '0;
          end else begin
            guardNxt = guardCnt + 1'b1;
          end
        end
        ST_HELD: begin
          if (settleCnt != SETTLE_DONE) begin
            settleNxt = settleCnt + 1'b1;
            if (settleCnt == SETTLE_LAST) strobes.setFlag = 1'b1;
          end
          if (earlySteer) begin
            guardNxt = '0;
          end else if (guardCnt == ABSENT_LAST) begin
            strobes.setFlag = 1'b0;
            strobes.clrFlag = 1'b1;
            stateNxt = ST_IDLE;
            guardNxt = '0;
          end else begin
            guardNxt = guardCnt + 1'b1;
          end
        end
        default: begin
          stateNxt = ST_IDLE;
          guardNxt = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      guardCnt  <= '0;
      settleCnt <= '0;
    end else begin
      state     <= stateNxt;
      guardCnt  <= guardNxt;
      settleCnt <= settleNxt;
    end
  end

  assign steerHeld = (state == ST_HELD);

endmodule

// File: rtl/dtmf_guard_datapath.sv
`timescale 1ns/1ps
module dtmf_guard_datapath
  import dtmf_guard_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  steerStrobes_t     strobes,
  input  logic [CODE_W-1:0] keyCode,
  input  logic              outEnable,
  output logic [CODE_W-1:0] codeOut,
  output logic              codeOutEn,
  output logic              delayedSteer
);

  logic [CODE_W-1:0] codeReg;
  logic              flagReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeReg <= '0;
      flagReg <= 1'b0;
    end else begin
      if (strobes.loadCode) codeReg <= keyCode;
      if (strobes.clrFlag)      flagReg <= 1'b0;
      else if (strobes.setFlag) flagReg <= 1'b1;
    end
  end

  assign codeOut      = outEnable ? codeReg : '0;
  assign codeOutEn    = outEnable;
  assign delayedSteer = flagReg;

endmodule

// File: rtl/dtmf_guard_ctrl.sv
`timescale 1ns/1ps
module dtmf_guard_ctrl
  import dtmf_guard_pkg::*;
#(
  parameter int PRESENT_TICKS = 16,
  parameter int ABSENT_TICKS  = 12,
  parameter int SETTLE_TICKS  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       earlySteer,
  input  logic [3:0] keyCode,
  input  logic       inhibit,
  input  logic       powerDown,
  input  logic       outEnable,
  output logic [3:0] codeOut,
  output logic       codeOutEn,
  output logic       delayedSteer
);

  steerStrobes_t strobes;
  logic          steerHeld;

  dtmf_guard_fsm #(
    .PRESENT_TICKS(PRESENT_TICKS),
    .ABSENT_TICKS (ABSENT_TICKS),
    .SETTLE_TICKS (SETTLE_TICKS)
  ) u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .earlySteer(earlySteer),
    .keyCode   (keyCode),
    .inhibit   (inhibit),
    .powerDown (powerDown),
    .strobes   (strobes),
    .steerHeld (steerHeld)
  );

  dtmf_guard_datapath #(
    .CODE_W(4)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .keyCode     (keyCode),
    .outEnable   (outEnable),
    .codeOut     (codeOut),
    .codeOutEn   (codeOutEn),
    .delayedSteer(delayedSteer)
  );

endmodule

// File: rtl/dtmf_guard_chk.sv
`timescale 1ns/1ps
module dtmf_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic       earlySteer,
  input logic       powerDown,
  input logic       outEnable,
  input logic [3:0] codeOut,
  input logic       codeOutEn,
  input logic       delayedSteer,
  input logic       steerHeld
);

  // R1
  code_needs_tone_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outEnable && $past(outEnable) && !$past(earlySteer)) |-> $stable(codeOut));

  // R2
  code_settled_at_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(delayedSteer) && outEnable && $past(outEnable)) |-> $stable(codeOut));

  // R3
  flag_fall_after_absence_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(delayedSteer) |-> (!$past(earlySteer) || $past(powerDown)));

  // R4
  flag_only_when_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    delayedSteer |-> steerHeld);

  // R5
  parked_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outEnable |-> (codeOut == 4'd0 && !codeOutEn));

  // R7
  powerdown_clears_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> !delayedSteer);

  // R7
  powerdown_keeps_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(powerDown) && outEnable && $past(outEnable)) |-> $stable(codeOut));

endmodule

bind dtmf_guard_ctrl dtmf_guard_chk u_guardChk (
  .clk         (clk),
  .rstN        (rstN),
  .earlySteer  (earlySteer),
  .powerDown   (powerDown),
  .outEnable   (outEnable),
  .codeOut     (codeOut),
  .codeOutEn   (codeOutEn),
  .delayedSteer(delayedSteer),
  .steerHeld   (steerHeld)
);

// File: tb/dtmf_guard_ctrl_tb.sv
`timescale 1ns/1ps
module dtmf_guard_ctrl_tb;

  localparam int P_T = 8;
  localparam int A_T = 6;
  localparam int S_T = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       earlySteer = 1'b0;
  logic [3:0] keyCode = 4'd0;
  logic       inhibit = 1'b0;
  logic       powerDown = 1'b0;
  logic       outEnable = 1'b1;
  logic [3:0] codeOut;
  logic       codeOutEn;
  logic       delayedSteer;

  int compared = 0;
  int mismatched = 0;
  logic [3:0] expQ[$];
  logic prevFlag = 1'b0;

  always #10 clk = ~clk;

  dtmf_guard_ctrl #(
    .PRESENT_TICKS(P_T),
    .ABSENT_TICKS (A_T),
    .SETTLE_TICKS (S_T)
  ) u_dut (
    .clk(clk), .rstN(rstN), .earlySteer(earlySteer), .keyCode(keyCode),
    .inhibit(inhibit), .powerDown(powerDown), .outEnable(outEnable),
    .codeOut(codeOut), .codeOutEn(codeOutEn), .delayedSteer(delayedSteer)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: called at a falling edge; pushes the code it expects to be registered
  task automatic playTone(input logic [3:0] key, input int hi, input int lo, input bit expectIt);
    if (expectIt) expQ.push_back(key);
    earlySteer = 1'b1;
    keyCode    = key;
    repeat (hi) @(negedge clk);
    earlySteer = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  // Monitor: every rise of delayedSteer must match the next expected code (R2)
  always @(negedge clk) begin
    if (rstN && delayedSteer && !prevFlag) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R1 unexpected registration", int'(codeOut), -1);
      end else begin
        logic [3:0] expCode;
        expCode = expQ.pop_front();
        check(codeOut == expCode, "R2 scoreboard code at flag rise", int'(codeOut), int'(expCode));
      end
    end
    prevFlag = delayedSteer;
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(delayedSteer == 1'b0, "R8 flag after reset", int'(delayedSteer), 0);
    check(codeOut == 4'd0, "R8 code after reset", int'(codeOut), 0);

    // R1/R2/R3 exact timing with key 5
    expQ.push_back(4'd5);
    earlySteer = 1'b1; keyCode = 4'd5;
    repeat (P_T - 1) @(negedge clk);
    check(codeOut == 4'd0, "R1 no capture one edge early", int'(codeOut), 0);
    @(negedge clk);
    check(codeOut == 4'd5, "R1 capture on accept edge", int'(codeOut), 5);
    check(delayedSteer == 1'b0, "R2 data ahead of flag", int'(delayedSteer), 0);
    earlySteer = 1'b0;
    repeat (S_T - 1) @(negedge clk);
    check(delayedSteer == 1'b0, "R2 flag not before settle", int'(delayedSteer), 0);
    @(negedge clk);
    check(delayedSteer == 1'b1, "R2 flag after settle", int'(delayedSteer), 1);
    repeat (A_T - S_T - 1) @(negedge clk);
    check(delayedSteer == 1'b1, "R3 flag held one edge before release", int'(delayedSteer), 1);
    @(negedge clk);
    check(delayedSteer == 1'b0, "R3 flag released after absence", int'(delayedSteer), 0);
    repeat (4) @(negedge clk);

    // R1 short burst rejected
    playTone(4'd9, P_T - 1, 10, 1'b0);
    check(codeOut == 4'd5, "R1 short burst leaves latch", int'(codeOut), 5);

    // R4 short dropout tolerated
    playTone(4'd3, P_T + 2, A_T - 2, 1'b1);
    check(delayedSteer == 1'b1, "R4 flag kept through dropout", int'(delayedSteer), 1);
    playTone(4'd7, 5, 10, 1'b0);
    check(codeOut == 4'd3, "R4 code after dropout not replaced", int'(codeOut), 3);
    check(delayedSteer == 1'b0, "R3 release after final absence", int'(delayedSteer), 0);

    // R5 output enable
    outEnable = 1'b0;
    @(negedge clk);
    check(codeOut == 4'd0, "R5 parked bus when disabled", int'(codeOut), 0);
    check(codeOutEn == 1'b0, "R5 drive enable low", int'(codeOutEn), 0);
    outEnable = 1'b1;
    @(negedge clk);
    check(codeOut == 4'd3, "R5 latch kept while disabled", int'(codeOut), 3);
    check(codeOutEn == 1'b1, "R5 drive enable high", int'(codeOutEn), 1);

    // R6 inhibit of letter keys
    inhibit = 1'b1;
    playTone(4'd14, P_T + 4, 10, 1'b0);
    check(codeOut == 4'd3, "R6 key B inhibited", int'(codeOut), 3);
    playTone(4'd10, P_T + 2, 10, 1'b1);
    check(codeOut == 4'd10, "R6 key 0 accepted under inhibit", int'(codeOut), 10);
    playTone(4'd0, P_T + 4, 10, 1'b0);
    check(codeOut == 4'd10, "R6 key D inhibited", int'(codeOut), 10);
    inhibit = 1'b0;
    playTone(4'd0, P_T + 2, 10, 1'b1);
    check(codeOut == 4'd0, "R6 key D accepted without inhibit", int'(codeOut), 0);

    // R7 power-down
    playTone(4'd6, P_T + 2, 2, 1'b1);
    check(delayedSteer == 1'b1, "R7 flag high before power-down", int'(delayedSteer), 1);
    powerDown = 1'b1;
    @(negedge clk);
    check(delayedSteer == 1'b0, "R7 flag cleared by power-down", int'(delayedSteer), 0);
    check(codeOut == 4'd6, "R7 latch kept at power-down", int'(codeOut), 6);
    playTone(4'd2, P_T + 4, 10, 1'b0);
    check(codeOut == 4'd6, "R7 no capture while powered down", int'(codeOut), 6);
    powerDown = 1'b0;
    @(negedge clk);
    playTone(4'd2, P_T + 2, 10, 1'b1);
    check(codeOut == 4'd2, "R7 capture resumes after power-up", int'(codeOut), 2);

    // R1/R6 full key sweep through the scoreboard
    for (int k = 1; k < 16; k++) begin
      playTone(4'(k), P_T + 1, A_T + 2, 1'b1);
    end
    check(codeOut == 4'd15, "R6 last swept key", int'(codeOut), 15);
    check(expQ.size() == 0, "R1 all expected registrations seen", expQ.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule